// File: doc/BRIEF.md
# LED Capacity Bar Display Driver

This block turns a relative remaining-capacity figure (0 to 125 percent) into drive for up to five LED segments and one common source switch. A pack controller supplies the percentage and two battery-voltage warnings, a nearly-empty flag and a final-empty flag. A user presses a push-button that pulls the display input low, and the block lights the LEDs for a fixed window.

The display encoding is chosen by a three-level configuration strap that is sampled only while reset is active. There are three encodings: a single moving dot, a two-LED binary code, and a cumulative bar. The segments are split into two banks that take turns in a short multiplexing frame, so that no more than one bank draws current at any moment.

All timing is counted in ticks of the `tick_en` clock enable. By default there are 1000 ticks per second, which gives a 100 Hz frame, a 4 Hz blink and on-times of 10 s or 4 s.

The control is a two-state machine:
- **ST_DARK**: the display is off. It moves to ST_LIT on a press.
- **ST_LIT**: the display is showing. A new press reloads the on-time. It moves back to ST_DARK on the tick that uses up the last unit of on-time.

Top module: `led_gauge_display`

## Requirements
- R1: The display mode is captured from `cfg_mode` while `rst_n` is low, with 2'b00 selecting the dot mode, 2'b01 the binary mode, and 2'b10 or 2'b11 the bar mode. Changes to `cfg_mode` after reset have no effect on the pattern.
- R2: In dot mode, exactly one of `seg_on[3:0]` carries the pattern. Bit 3 is used for 90 to 100 percent, bit 2 for 50 to 89, bit 1 for 20 to 49, and bit 0 for below 20.
- R3: In binary mode, only `seg_on[1:0]` are used. Both are set for 70 percent and above, bit 0 alone for 40 to 69, bit 1 alone for 10 to 39, and none below 10. The nearly-empty flag has no effect in this mode.
- R4: In bar mode, `seg_on[k-1:0]` are set with k = 1 plus one for each of the thresholds 20, 40, 60 and 80 that the level reaches.
- R5: In dot and bar modes, while `edv1` is high and `edvf` is low, only `seg_on[0]` may carry the pattern. It is on during the odd half-periods of a blink that toggles every BLINK_HALF ticks, counted from reset and starting in the off half.
- R6: While `edvf` is high, every bit of `seg_on` is zero in all modes.
- R7: The display lights when `disp_n` is sampled low at a clock edge after it was sampled high at the previous edge. The on-time lasts 10*TICKS_PER_SEC ticks in dot mode and 4*TICKS_PER_SEC ticks otherwise. A new press restarts the on-time. Outside the window, `seg_on` is zero and `com_en` is low. After reset, `disp_n` counts as previously high.
- R8: A frame phase counts ticks modulo MUX_PERIOD from reset. Bank A (`seg_on` bits 0, 2, 4) may be set only in phases 0 to BANK_ON-1, and bank B (bits 1, 3) only in phases BANK_ON to 2*BANK_ON-1. `com_en` is high during the window exactly in those phases.
- R9: A percentage above 100 is treated as 100 for every threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; mode strap sampled while low |
| tick_en | input | 1 | Timebase clock enable (TICKS_PER_SEC per second) |
| cfg_mode | input | 2 | Three-level mode strap: 00 dot, 01 binary, 1x bar |
| disp_n | input | 1 | Push-button, active low |
| pct | input | PCT_W | Relative remaining capacity, 0 to 125 |
| edv1 | input | 1 | Nearly-empty flag |
| edvf | input | 1 | Final-empty flag |
| seg_on | output | 5 | Segment sink enables, bit 0 is the first segment |
| com_en | output | 1 | Common source enable; low means high impedance |

## Verification
The segment outputs depend combinationally on `pct`, `edv1` and `edvf`, so a change to any of these shows in the same cycle. A press is registered at the next clock edge, and the display is lit from the cycle after the edge at which `disp_n` is first sampled low. The frame phase, the blink and the on-time all advance only on edges where `tick_en` is high. The bench keeps its own tick-based model that updates at each rising edge from the inputs in force there. It compares both outputs at every falling edge and drives new stimulus only after the comparison, so each expected value belongs to the same registered state as the design's.

// File: rtl/led_disp_pkg.sv
package led_disp_pkg;

    localparam int unsigned SEG_N = 5;

    typedef enum logic [1:0] {
        MODE_INC = 2'd0,
        MODE_BIN = 2'd1,
        MODE_BAR = 2'd2
    } mode_e;

    typedef enum logic {
        ST_DARK = 1'b0,
        ST_LIT  = 1'b1
    } disp_state_e;

    // Three-level strap: low, high, float (float may read as 10 or 11)
    function automatic mode_e decode_cfg(input logic [1:0] c);
        mode_e m;
        case (c)
            2'b00:   m = MODE_INC;
            2'b01:   m = MODE_BIN;
            default: m = MODE_BAR;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/disp_timebase.sv
module disp_timebase #(
    parameter int unsigned MUX_PERIOD = 10,
    parameter int unsigned BANK_ON    = 3,
    parameter int unsigned BLINK_HALF = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    output logic bank_a,
    output logic bank_b,
    output logic blink_on
);
    localparam int unsigned MW = $clog2(MUX_PERIOD + 1);
    localparam int unsigned BW = $clog2(BLINK_HALF + 1);

    logic [MW-1:0] mux_ph;
    logic [BW-1:0] blk_cnt;

    // R8: frame phase advances on ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mux_ph <= '0;
        end else if (tick_en) begin
            mux_ph <= (mux_ph == MW'(MUX_PERIOD - 1)) ? '0 : mux_ph + 1'b1;
        end
    end

    // R5: blink half-period counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_cnt  <= '0;
            blink_on <= 1'b0;
        end else if (tick_en) begin
            if (blk_cnt == BW'(BLINK_HALF - 1)) begin
                blk_cnt  <= '0;
                blink_on <= ~blink_on;
            end else begin
                blk_cnt <= blk_cnt + 1'b1;
            end
        end
    end

    assign bank_a = (mux_ph < MW'(BANK_ON));
    assign bank_b = (mux_ph >= MW'(BANK_ON)) && (mux_ph < MW'(2 * BANK_ON));

endmodule

// File: rtl/disp_pattern.sv
module disp_pattern
    import led_disp_pkg::*;
#(
    parameter int unsigned PCT_W = 7
) (
    input  mode_e             mode,
    input  logic [PCT_W-1:0]  pct,
    input  logic              edv1,
    input  logic              edvf,
    input  logic              blink_on,
    output logic [SEG_N-1:0]  pat
);
    localparam logic [PCT_W-1:0] P100 = PCT_W'(100);
    localparam logic [PCT_W-1:0] P90  = PCT_W'(90);
    localparam logic [PCT_W-1:0] P80  = PCT_W'(80);
    localparam logic [PCT_W-1:0] P70  = PCT_W'(70);
    localparam logic [PCT_W-1:0] P60  = PCT_W'(60);
    localparam logic [PCT_W-1:0] P50  = PCT_W'(50);
    localparam logic [PCT_W-1:0] P40  = PCT_W'(40);
    localparam logic [PCT_W-1:0] P20  = PCT_W'(20);
    localparam logic [PCT_W-1:0] P10  = PCT_W'(10);

    logic [PCT_W-1:0] lvl;

    always_comb begin
        // R9: saturate for comparison
        lvl = (pct > P100) ? P100 : pct;
        pat = '0;
        unique case (mode)
            MODE_INC: begin   // R2, R5
                if (edv1)            pat[0] = blink_on;
                else if (lvl >= P90) pat[3] = 1'b1;
                else if (lvl >= P50) pat[2] = 1'b1;
                else if (lvl >= P20) pat[1] = 1'b1;
                else                 pat[0] = 1'b1;
            end
            MODE_BIN: begin   // R3
                if (lvl >= P70)      pat = 5'b00011;
                else if (lvl >= P40) pat = 5'b00001;
                else if (lvl >= P10) pat = 5'b00010;
                else                 pat = 5'b00000;
            end
            MODE_BAR: begin   // R4, R5
                if (edv1)            pat[0] = blink_on;
                else if (lvl >= P80) pat = 5'b11111;
                else if (lvl >= P60) pat = 5'b01111;
                else if (lvl >= P40) pat = 5'b00111;
                else if (lvl >= P20) pat = 5'b00011;
                else                 pat = 5'b00001;
            end
            default: pat = '0;
        endcase
        if (edvf) pat = '0;   // R6
    end

endmodule

// File: rtl/led_gauge_display.sv
module led_gauge_display
    import led_disp_pkg::*;
#(
    parameter int unsigned TICKS_PER_SEC = 1000,
    parameter int unsigned MUX_PERIOD    = 10,
    parameter int unsigned BANK_ON       = 3,
    parameter int unsigned BLINK_HALF    = 125,
    parameter int unsigned PCT_W         = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic [1:0]       cfg_mode,
    input  logic             disp_n,
    input  logic [PCT_W-1:0] pct,
    input  logic             edv1,
    input  logic             edvf,
    output logic [4:0]       seg_on,
    output logic             com_en
);
    localparam int unsigned ON_INC = 10 * TICKS_PER_SEC;
    localparam int unsigned ON_OTH = 4 * TICKS_PER_SEC;
    localparam int unsigned TW     = $clog2(ON_INC + 1);

    mode_e         mode_q;
    disp_state_e   state_q, state_d;
    logic [TW-1:0] timer_q, timer_d;
    logic          disp_q;
    logic          press;
    logic [TW-1:0] load_val;
    logic          bank_a, bank_b, blink_on;
    logic [SEG_N-1:0] pat, bank_mask;

    disp_timebase #(
        .MUX_PERIOD (MUX_PERIOD),
        .BANK_ON    (BANK_ON),
        .BLINK_HALF (BLINK_HALF)
    ) u_tb (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .bank_a   (bank_a),
        .bank_b   (bank_b),
        .blink_on (blink_on)
    );

    disp_pattern #(
        .PCT_W (PCT_W)
    ) u_pat (
        .mode     (mode_q),
        .pct      (pct),
        .edv1     (edv1),
        .edvf     (edvf),
        .blink_on (blink_on),
        .pat      (pat)
    );

    // R7: falling edge of the button
    assign press    = disp_q & ~disp_n;
    assign load_val = (mode_q == MODE_INC) ? TW'(ON_INC - 1) : TW'(ON_OTH - 1);

    // State register; R1 mode captured only under reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= decode_cfg(cfg_mode);
            state_q <= ST_DARK;
            timer_q <= '0;
            disp_q  <= 1'b1;
        end else begin
            state_q <= state_d;
            timer_q <= timer_d;
            disp_q  <= disp_n;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        timer_d = timer_q;
        unique case (state_q)
            ST_DARK: begin
                if (press) begin
                    state_d = ST_LIT;
                    timer_d = load_val;
                end
            end
            ST_LIT: begin
                if (press) begin
                    timer_d = load_val;
                end else if (tick_en) begin
                    if (timer_q == '0) state_d = ST_DARK;
                    else               timer_d = timer_q - 1'b1;
                end
            end
            default: state_d = ST_DARK;
        endcase
    end

    // Outputs; R8 bank multiplexing
    always_comb begin
        bank_mask = {bank_a, bank_b, bank_a, bank_b, bank_a};
        if (state_q == ST_LIT) begin
            seg_on = pat & bank_mask;
            com_en = bank_a | bank_b;
        end else begin
            seg_on = '0;
            com_en = 1'b0;
        end
    end

endmodule

// File: rtl/led_gauge_display_chk.sv
module led_gauge_display_chk
    import led_disp_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input mode_e      mode,
    input logic [4:0] seg_on,
    input logic       com_en,
    input logic       edv1,
    input logic       edvf
);
    a_r1_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(mode));

    a_r2_single_dot: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_INC) |-> ($onehot0(seg_on) && !seg_on[4]));

    a_r3_two_pins: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_BIN) |-> (seg_on[4:2] == 3'b000));

    a_r5_blink_only_first: assert property (@(posedge clk) disable iff (!rst_n)
        (edv1 && !edvf && mode != MODE_BIN) |-> (seg_on[4:1] == 4'b0000));

    a_r6_final_dark: assert property (@(posedge clk) disable iff (!rst_n)
        edvf |-> (seg_on == 5'b00000));

    a_r7_no_source_no_sink: assert property (@(posedge clk) disable iff (!rst_n)
        !com_en |-> (seg_on == 5'b00000));

    a_r8_banks_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !((|{seg_on[4], seg_on[2], seg_on[0]}) && (|{seg_on[3], seg_on[1]})));

endmodule

bind led_gauge_display led_gauge_display_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode   (mode_q),
    .seg_on (seg_on),
    .com_en (com_en),
    .edv1   (edv1),
    .edvf   (edvf)
);

// File: tb/tb_led_gauge_display.sv
`timescale 1ns/1ps
module tb_led_gauge_display;
    localparam int TPS = 1000;
    localparam int MP  = 10;
    localparam int BON = 3;
    localparam int BH  = 125;

    logic       clk = 1'b0;
    logic       rst_n, tick_en, disp_n, edv1, edvf;
    logic [1:0] cfg_mode;
    logic [6:0] pct;
    logic [4:0] seg_on;
    logic       com_en;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // model state
    int m_mode, m_left, m_mph, m_bcnt;
    bit m_lit, m_blink, m_dprev;

    always #5 clk = ~clk;

    led_gauge_display dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cfg_mode(cfg_mode),
        .disp_n(disp_n), .pct(pct), .edv1(edv1), .edvf(edvf),
        .seg_on(seg_on), .com_en(com_en)
    );

    function automatic int mode_of(input logic [1:0] c);
        if (c == 2'b00) return 0;
        if (c == 2'b01) return 1;
        return 2;
    endfunction

    function automatic logic [4:0] exp_pat(input int md, input int p, input bit e1,
                                           input bit ef, input bit bl);
        int lv, k;
        lv = (p > 100) ? 100 : p;
        if (ef) return 5'b0;
        if (md == 0) begin
            if (e1) return {4'b0, bl};
            if (lv >= 90) return 5'b01000;
            if (lv >= 50) return 5'b00100;
            if (lv >= 20) return 5'b00010;
            return 5'b00001;
        end else if (md == 1) begin
            case ({lv >= 70, lv >= 40, lv >= 10})
                3'b111:  return 5'b00011;
                3'b011:  return 5'b00001;
                3'b001:  return 5'b00010;
                default: return 5'b00000;
            endcase
        end
        if (e1) return {4'b0, bl};
        k = 1 + int'(lv >= 20) + int'(lv >= 40) + int'(lv >= 60) + int'(lv >= 80);
        return 5'((1 << k) - 1);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = mode_of(cfg_mode);
            m_lit = 0; m_left = 0; m_mph = 0; m_bcnt = 0; m_blink = 0; m_dprev = 1;
        end else begin
            if (m_dprev && !disp_n) begin
                m_lit  = 1;
                m_left = (m_mode == 0 ? 10 : 4) * TPS;
            end else if (m_lit && tick_en) begin
                m_left--;
                if (m_left == 0) m_lit = 0;
            end
            if (tick_en) begin
                m_mph = (m_mph + 1) % MP;
                m_bcnt++;
                if (m_bcnt == BH) begin m_bcnt = 0; m_blink = !m_blink; end
            end
            m_dprev = disp_n;
        end
    end

    task automatic check_now();
        logic [4:0] es, mask;
        bit ea, eb, ec;
        string tag;
        ea = (m_mph < BON);
        eb = (m_mph >= BON) && (m_mph < 2 * BON);
        mask = {ea, eb, ea, eb, ea};
        es = m_lit ? (exp_pat(m_mode, int'(pct), edv1, edvf, m_blink) & mask) : 5'b0;
        ec = m_lit && (ea || eb);
        if (!m_lit)                               tag = "R7";
        else if (mode_of(cfg_mode) != m_mode)     tag = "R1";
        else if (edvf)                            tag = "R6";
        else if (edv1 && m_mode != 1)             tag = "R5";
        else if (pct > 100)                       tag = "R9";
        else if (m_mode == 0)                     tag = "R2";
        else if (m_mode == 1)                     tag = "R3";
        else                                      tag = "R4";
        n_checks++;
        if (seg_on !== es) begin
            n_fail++;
            $display("FAIL %s seg_on act=%b exp=%b pct=%0d t=%0t", tag, seg_on, es, pct, $time);
        end
        n_checks++;
        if (com_en !== ec) begin
            n_fail++;
            $display("FAIL R8 com_en act=%b exp=%b t=%0t", com_en, ec, $time);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (rst_n) check_now();
        end
    endtask

    task automatic run_mode(input logic [1:0] cfg);
        int pts[20] = '{0, 9, 10, 19, 20, 39, 40, 49, 50, 59, 60, 69, 70, 79, 80, 89, 90, 100, 101, 125};
        @(negedge clk);
        rst_n = 0; cfg_mode = cfg; disp_n = 1; tick_en = 0; edv1 = 0; edvf = 0; pct = 7'd50;
        cyc(3);
        rst_n = 1;
        cyc(1);
        // reset state: dark (R7)
        n_checks++;
        if (seg_on !== 5'b0 || com_en !== 1'b0) begin
            n_fail++;
            $display("FAIL R7 reset act=%b/%b exp=00000/0", seg_on, com_en);
        end
        cyc(5);
        cfg_mode = cfg ^ 2'b01;   // R1: strap changes after reset ignored
        disp_n = 0; cyc(2); disp_n = 1;
        tick_en = 1;
        foreach (pts[i]) begin    // R2 R3 R4 R9 thresholds
            pct = 7'(pts[i]);
            cyc(12);
        end
        pct = 7'd85; edv1 = 1; cyc(300);   // R5 blink
        edvf = 1; cyc(20);                  // R6
        edv1 = 0; cyc(15); edvf = 0;
        disp_n = 0; cyc(1); disp_n = 1;     // R7 re-press
        cyc(10 * TPS + 50);                 // R7 window expiry
        for (int i = 0; i < 4000; i++) begin
            tick_en = ($urandom % 4) != 0;
            pct     = 7'($urandom % 126);
            edv1    = ($urandom % 16) == 0;
            edvf    = ($urandom % 32) == 0;
            disp_n  = ($urandom % 300) == 0 ? 1'b0 : 1'b1;
            if (($urandom % 50) == 0) cfg_mode = 2'($urandom);
            cyc(1);
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        rst_n = 0; cfg_mode = 0; disp_n = 1; tick_en = 0; edv1 = 0; edvf = 0; pct = 0;
        run_mode(2'b00);
        run_mode(2'b01);
        run_mode(2'b10);
        run_mode(2'b11);
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule